// File: doc/BRIEF.md
# Null-Free Byte Stuffing Frame Encoder

This block turns a payload of up to 254 bytes into a zero-free byte stream that ends with one 0x00 delimiter. It uses Consistent Overhead Byte Stuffing (COBS). A receiver can then find every frame boundary just by looking for the next zero. The payload is written into an internal buffer through a simple indexed write port. A start strobe with a length begins the encode.

The encoder splits the payload at each zero byte into runs. It first scans forward to measure the current run. It then emits a code byte, equal to the run length plus one, followed by the run's own bytes. The zero that ended the run is not sent; the code byte carries its position. The final run ends at the payload length rather than at a zero, and it also gets a code byte. Output bytes leave on a valid/ready interface. A one-cycle done pulse marks the end of the frame.

Top module: `cobs_encoder`

## Requirements
- R1: Every run of non-zero payload bytes is sent as one code byte of value (run length + 1), followed by the run's bytes in payload order.
- R2: A zero payload byte is never transmitted. It only closes a run, so each zero adds one run: payload 00 gives 01 01 00, and payload 00 00 gives 01 01 01 00.
- R3: The final run is bounded by the payload length and still gets its code byte. Payload 11 22 00 33 gives 03 11 22 02 33 00, payload 11 22 33 44 gives 05 11 22 33 44 00, and an empty payload gives 01 00.
- R4: Each frame ends with exactly one 0x00 byte on the output, and no other output byte of the frame is zero.
- R5: While the output is valid but not ready, valid stays high and the data stays unchanged, so no byte is lost or repeated.
- R6: While busy, the start input and buffer writes are ignored. The running frame is unaffected, and the buffer content is unchanged for a later frame.
- R7: Busy rises in the cycle after a start is taken while idle. It stays high through the cycle in which the delimiter is accepted. In the following cycle busy is low and done is high for exactly one cycle.
- R8: A 254-byte non-zero run is sent with code byte 0xFF. A length above 254 is treated as 254.
- R9: During and right after reset, busy, done and output valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write strobe for the payload buffer (ignored while busy) |
| ld_addr | input | 8 | Payload buffer write index |
| ld_data | input | 8 | Payload byte to write |
| start | input | 1 | Begin encoding (taken only while idle) |
| frame_len | input | 8 | Payload length in bytes, sampled with start |
| busy | output | 1 | Encode in progress |
| done | output | 1 | One-cycle pulse after the delimiter is accepted |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Encoded output byte |

## Verification
On every cycle, the checker confirms four things. A stalled byte holds its value. Valid never appears outside busy. A zero on the output is always followed by done and idle. Done is a single-cycle pulse that only follows an accepted delimiter. The exact run lengths, byte order, zero removal, length clamping, and the fact that buffer writes and restarts during a frame change nothing can only be shown by the scenarios. The bench compares each output byte against an encoding it computes independently, under both continuous and randomly stalled ready.

// File: rtl/cobs_pkg.sv
package cobs_pkg;
    localparam int BYTE_W  = 8;
    localparam int MAX_LEN = 254;
    localparam int IDX_W   = $clog2(MAX_LEN + 1);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_CODE,
        ST_DATA,
        ST_DELIM
    } state_e;

    typedef enum logic [1:0] {
        OUT_CODE,
        OUT_DATA,
        OUT_DELIM
    } out_kind_e;

    // Cursor over the payload: start of the current run, scan head,
    // measured run length and frame length.
    typedef struct packed {
        idx_t base;
        idx_t scan;
        idx_t run;
        idx_t len;
    } cursor_t;

    function automatic byte_t code_of(idx_t run);
        return BYTE_W'(run) + BYTE_W'(1);
    endfunction

    function automatic idx_t clamp_len(idx_t l);
        return (l > IDX_W'(MAX_LEN)) ? IDX_W'(MAX_LEN) : l;
    endfunction
endpackage

// File: rtl/cobs_buf.sv
module cobs_buf
    import cobs_pkg::*;
#(
    parameter int DEPTH = MAX_LEN
) (
    input  logic  clk,
    input  logic  we,
    input  idx_t  waddr,
    input  byte_t wdata,
    input  idx_t  ra_addr,
    output byte_t ra_data,
    input  idx_t  rb_addr,
    output byte_t rb_data
);
    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH))
            mem[waddr] <= wdata;
    end

    always_comb begin
        ra_data = (int'(ra_addr) < DEPTH) ? mem[ra_addr] : '0;
        rb_data = (int'(rb_addr) < DEPTH) ? mem[rb_addr] : '0;
    end
endmodule

// File: rtl/cobs_ctrl.sv
module cobs_ctrl
    import cobs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  idx_t      len_in,
    input  byte_t     scan_byte,
    input  logic      out_ready,
    output idx_t      scan_addr,
    output idx_t      data_addr,
    output out_kind_e out_kind,
    output byte_t     code_byte,
    output logic      out_valid,
    output logic      busy,
    output logic      done
);
    state_e  st;
    cursor_t cur;
    idx_t    rd;
    logic    at_end;
    logic    run_closed;
    logic    leave_run;

    assign at_end     = (cur.scan == cur.len);
    assign run_closed = at_end || (scan_byte == '0);
    assign leave_run  = out_ready &&
                        (((st == ST_CODE) && (cur.run == '0)) ||
                         ((st == ST_DATA) && (rd + idx_t'(1) == cur.scan)));

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cur  <= '0;
            rd   <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    cur.len  <= clamp_len(len_in);
                    cur.base <= '0;
                    cur.scan <= '0;
                    cur.run  <= '0;
                    st       <= ST_SCAN;
                end
                ST_SCAN: begin
                    if (run_closed) begin
                        st <= ST_CODE;
                    end else begin
                        cur.scan <= cur.scan + idx_t'(1);
                        cur.run  <= cur.run + idx_t'(1);
                    end
                end
                ST_CODE: if (out_ready && (cur.run != '0)) begin
                    rd <= cur.base;
                    st <= ST_DATA;
                end
                ST_DATA: if (out_ready) rd <= rd + idx_t'(1);
                ST_DELIM: if (out_ready) begin
                    st   <= ST_IDLE;
                    done <= 1'b1;
                end
                default: st <= ST_IDLE;
            endcase

            if (leave_run) begin
                if (at_end) begin
                    st <= ST_DELIM;
                end else begin
                    cur.base <= cur.scan + idx_t'(1);
                    cur.scan <= cur.scan + idx_t'(1);
                    cur.run  <= '0;
                    st       <= ST_SCAN;
                end
            end
        end
    end

    always_comb begin
        scan_addr = cur.scan;
        data_addr = rd;
        code_byte = code_of(cur.run);
        busy      = (st != ST_IDLE);
        out_valid = (st == ST_CODE) || (st == ST_DATA) || (st == ST_DELIM);
        case (st)
            ST_DATA:  out_kind = OUT_DATA;
            ST_DELIM: out_kind = OUT_DELIM;
            default:  out_kind = OUT_CODE;
        endcase
    end
endmodule

// File: rtl/cobs_encoder.sv
module cobs_encoder
    import cobs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ld_en,
    input  logic [7:0] ld_addr,
    input  logic [7:0] ld_data,
    input  logic       start,
    input  logic [7:0] frame_len,
    output logic       busy,
    output logic       done,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data
);
    idx_t      scan_addr;
    idx_t      data_addr;
    byte_t     scan_byte;
    byte_t     run_byte;
    byte_t     code_byte;
    out_kind_e out_kind;

    cobs_buf #(.DEPTH(MAX_LEN)) i_buf (
        .clk     (clk),
        .we      (ld_en && !busy),
        .waddr   (ld_addr),
        .wdata   (ld_data),
        .ra_addr (scan_addr),
        .ra_data (scan_byte),
        .rb_addr (data_addr),
        .rb_data (run_byte)
    );

    cobs_ctrl i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .len_in    (frame_len),
        .scan_byte (scan_byte),
        .out_ready (out_ready),
        .scan_addr (scan_addr),
        .data_addr (data_addr),
        .out_kind  (out_kind),
        .code_byte (code_byte),
        .out_valid (out_valid),
        .busy      (busy),
        .done      (done)
    );

    always_comb begin
        case (out_kind)
            OUT_DATA:  out_data = run_byte;
            OUT_DELIM: out_data = '0;
            default:   out_data = code_byte;
        endcase
    end
endmodule

// File: rtl/cobs_encoder_chk.sv
module cobs_encoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data
);
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_valid_in_busy_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_delim_closes_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && (out_data == 8'h00)) |=> (done && !busy));

    assert_done_after_delim_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(out_valid && out_ready && (out_data == 8'h00)));

    assert_busy_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && !(out_valid && out_ready && (out_data == 8'h00))) |=> busy);

    assert_reset_quiet_R9: assert property (@(posedge clk)
        rst |=> (!busy && !done && !out_valid));
endmodule

bind cobs_encoder cobs_encoder_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/test_cobs_encoder.sv
module test_cobs_encoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_en = 1'b0;
    logic [7:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic       start = 1'b0;
    logic [7:0] frame_len = '0;
    logic       busy, done, out_valid, out_data_dummy;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;

    int         n_cmp = 0;
    int         n_bad = 0;
    logic [7:0] exp_q [$];
    logic [7:0] pl [256];
    string      cur_tag = "R1";
    bit         stall_mode = 1'b0;
    bit         finished = 1'b0;
    logic       prev_stall = 1'b0;
    logic [7:0] prev_data = '0;

    assign out_data_dummy = 1'b0;

    always #2 clk = ~clk;

    cobs_encoder i_cobs_encoder (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .start(start), .frame_len(frame_len), .busy(busy), .done(done),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Ready pattern, changed just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1 out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
        end
    end

    // Monitor: pops the scoreboard on each accepted byte.
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall)
                check("R5 stalled byte held", {out_valid, out_data}, {1'b1, prev_data});
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check({cur_tag, " unexpected byte"}, out_data, 256);
                end else begin
                    check({cur_tag, " byte"}, out_data, exp_q.pop_front());
                end
            end
        end
    end

    function automatic void expect_frame(int n);
        int base = 0;
        for (int i = 0; i <= n; i++) begin
            if (i == n || pl[i] == 8'h00) begin
                exp_q.push_back(8'(i - base + 1));
                for (int k = base; k < i; k++) exp_q.push_back(pl[k]);
                base = i + 1;
            end
        end
        exp_q.push_back(8'h00);
    endfunction

    task automatic load(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1 ld_en = 1'b1; ld_addr = 8'(i); ld_data = pl[i];
        end
        @(posedge clk);
        #1 ld_en = 1'b0;
    endtask

    task automatic kick(int len);
        @(posedge clk);
        #1 start = 1'b1; frame_len = 8'(len);
        @(posedge clk);
        #1 start = 1'b0;
        check("R7 busy after start", busy, 1);
    endtask

    task automatic wait_done(int clash);
        int t = 0;
        int seen = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
            if (clash != 0 && t == 3) begin
                // R6: restart and overwrite while busy
                fork
                    begin
                        @(posedge clk);
                        #1 start = 1'b1; frame_len = 8'd1;
                        ld_en = 1'b1; ld_addr = 8'd0; ld_data = 8'h77;
                        @(posedge clk);
                        #1 start = 1'b0; ld_en = 1'b0;
                    end
                join_none
            end
        end
        check("R7 done seen", done, 1);
        check("R7 idle with done", busy, 0);
        @(negedge clk);
        seen = done;
        check("R7 done single cycle", seen, 0);
        check({cur_tag, " all bytes emitted"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic run(string tag, int n, int len, int clash);
        cur_tag = tag;
        load(n);
        expect_frame(n);
        kick(len);
        wait_done(clash);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9 busy in reset", busy, 0);
        check("R9 valid in reset", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 done after reset", done, 0);
        check("R9 valid after reset", out_valid, 0);

        pl[0] = 8'h11; pl[1] = 8'h22; pl[2] = 8'h00; pl[3] = 8'h33;
        run("R3 11 22 00 33", 4, 4, 0);
        pl[0] = 8'h11; pl[1] = 8'h22; pl[2] = 8'h33; pl[3] = 8'h44;
        run("R1 11 22 33 44", 4, 4, 0);
        run("R3 empty payload", 0, 0, 0);
        pl[0] = 8'h00;
        run("R2 single zero", 1, 1, 0);
        pl[0] = 8'h00; pl[1] = 8'h00;
        run("R2 two zeros", 2, 2, 0);
        pl[0] = 8'h11; pl[1] = 8'h00; pl[2] = 8'h00; pl[3] = 8'h00;
        run("R2 trailing zeros", 4, 4, 0);

        stall_mode = 1'b1;
        for (int i = 0; i < 40; i++) pl[i] = ((i % 7) == 3) ? 8'h00 : 8'(i * 13 + 1);
        run("R5 stalled mixed", 40, 40, 0);

        stall_mode = 1'b0;
        for (int i = 0; i < 254; i++) pl[i] = 8'((i % 255) + 1);
        run("R8 full run", 254, 254, 0);
        expect_frame(254);
        cur_tag = "R8 clamp 255";
        kick(255);
        wait_done(0);

        pl[0] = 8'h5A; pl[1] = 8'h00; pl[2] = 8'hA5;
        run("R6 start while busy", 3, 3, 1);
        expect_frame(3);
        cur_tag = "R6 buffer kept";
        kick(3);
        wait_done(0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule